// File: doc/BRIEF.md
# Flash Page Write-Protect Guard

This block sits in front of a flash programming controller and decides, for each erase or write request, whether the target page may be touched. The decision comes from a small configuration word. Software or a boot loader loads that word once after power-on. The word holds a boundary page, a direction bit that selects whether the protected span lies below or above the boundary, a bit that switches the span off, and a bit that keeps the topmost page open. The topmost page holds the device configuration words.

A request is a page number together with a one-cycle strobe. One clock later the block answers with exactly one of two pulses. A go pulse lets the programming sequencer act. A violation pulse reports the refusal, and in that case the sequencer sees no go. The number of pages, and therefore the index of the configuration page, follows from the flash size parameter. Page numbers above that index are always refused. After the configuration word has been taken, any further load is discarded and raises a sticky error flag.

Top module: `fwp_guard`

## Requirements
- R1: After reset the configuration word is all ones (span switched off, configuration page open). Every page from 0 to the last page is allowed, and no error is flagged.
- R2: The last page index equals FLASH_KB*1024/PAGE_BYTES - 1. A request for any page above it is always refused with a violation pulse.
- R3: With the direction bit (cfg_wdata[7]) at 1 and the span enabled, pages from the boundary (cfg_wdata[6:0]) up to and including the last page are refused, and lower pages are allowed.
- R4: With the direction bit at 0 and the span enabled, pages 0 through the boundary are refused, and higher pages are allowed.
- R5: With the span-off bit (cfg_wdata[8]) at 1, the boundary and direction have no effect on any page.
- R6: With the config-open bit (cfg_wdata[9]) at 0, the last page is refused whatever the span settings are.
- R7: With the config-open bit at 1, the last page is refused only when the enabled span covers it.
- R8: The first load (cfg_we high for one cycle) takes effect for requests from the next cycle on. Every later load is ignored and sets cfg_err, which stays high until reset.
- R9: A request presented in one cycle produces, in the following cycle only, exactly one of prog_go or viol_pulse. With no request, both stay low.
- R10: The boundary is compared at its full seven bits. With the direction bit at 1, a boundary above the last page covers no page.

Parameters: FLASH_KB (flash size in KB, default 64), PAGE_BYTES (default 1024), REQ_PAGE_W (request page width, default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 10 | {cfg_open, span_off, dir_up, boundary[6:0]} |
| req_valid | input | 1 | Erase/write request strobe |
| req_page | input | REQ_PAGE_W | Target page of the request |
| prog_go | output | 1 | One-cycle grant to the programming sequencer |
| viol_pulse | output | 1 | One-cycle pulse for a refused request |
| cfg_err | output | 1 | Sticky flag: a repeated configuration load was attempted |

## Verification
The bench builds the guard with FLASH_KB=16 and REQ_PAGE_W=5. This gives 16 pages, so page 15 is the configuration page, and the request range runs up to page 31. Every page, including several beyond the last one, can therefore be swept under each configuration. The boundary values swept include 0, the last page, one past it, and 127. Combined with all eight settings of the three control bits, this reaches the out-of-range boundary and both edges of each span. A fresh reset before each configuration lets the once-only load be tested repeatedly, including the rejected second load.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int BND_W = 7;

    typedef struct packed {
        logic             cfg_open;   // 1: config page not forced protected
        logic             span_off;   // 1: boundary/direction span ignored
        logic             dir_up;     // 1: span is boundary..last, 0: 0..boundary
        logic [BND_W-1:0] bnd;
    } fwp_cfg_t;

    localparam int CFG_W = $bits(fwp_cfg_t);
endpackage

// File: rtl/fwp_cfg_store.sv
module fwp_cfg_store
    import fwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  fwp_cfg_t wr_data,
    output fwp_cfg_t cfg_o,
    output logic     err_o
);
    typedef struct packed {
        fwp_cfg_t cfg;
        logic     taken;
        logic     err;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!st_q.taken) begin
                st_d.cfg   = wr_data;
                st_d.taken = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= '1;
            st_q.taken <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign err_o = st_q.err;
endmodule

// File: rtl/fwp_region_eval.sv
module fwp_region_eval
    import fwp_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int LAST_PAGE = 63
) (
    input  fwp_cfg_t          cfg,
    input  logic [PAGE_W-1:0] page,
    output logic              deny
);
    localparam int CMP_W = (PAGE_W > BND_W) ? PAGE_W : BND_W;
    localparam logic [CMP_W-1:0] LAST_X = CMP_W'(LAST_PAGE);

    logic [CMP_W-1:0] page_x;
    logic [CMP_W-1:0] bnd_x;
    logic             beyond;
    logic             span_hit;
    logic             is_cfg_page;

    always_comb begin
        page_x      = CMP_W'(page);
        bnd_x       = CMP_W'(cfg.bnd);
        beyond      = page_x > LAST_X;
        is_cfg_page = page_x == LAST_X;
        if (cfg.span_off) begin
            span_hit = 1'b0;
        end else if (cfg.dir_up) begin
            span_hit = page_x >= bnd_x;
        end else begin
            span_hit = page_x <= bnd_x;
        end
        deny = beyond || span_hit || (is_cfg_page && !cfg.cfg_open);
    end
endmodule

// File: rtl/fwp_req_stage.sv
module fwp_req_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic deny,
    output logic go,
    output logic viol
);
    typedef struct packed {
        logic go;
        logic viol;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d.go   = valid && !deny;
        rs_d.viol = valid && deny;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign go   = rs_q.go;
    assign viol = rs_q.viol;
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard
    import fwp_pkg::*;
#(
    parameter int FLASH_KB   = 64,
    parameter int PAGE_BYTES = 1024,
    parameter int REQ_PAGE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  req_valid,
    input  logic [REQ_PAGE_W-1:0] req_page,
    output logic                  prog_go,
    output logic                  viol_pulse,
    output logic                  cfg_err
);
    localparam int NUM_PAGES = (FLASH_KB * 1024) / PAGE_BYTES;
    localparam int LAST_PAGE = NUM_PAGES - 1;

    fwp_cfg_t cfg_now;
    logic     deny_now;

    fwp_cfg_store store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (fwp_cfg_t'(cfg_wdata)),
        .cfg_o   (cfg_now),
        .err_o   (cfg_err)
    );

    fwp_region_eval #(
        .PAGE_W    (REQ_PAGE_W),
        .LAST_PAGE (LAST_PAGE)
    ) eval_i (
        .cfg  (cfg_now),
        .page (req_page),
        .deny (deny_now)
    );

    fwp_req_stage resp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (req_valid),
        .deny  (deny_now),
        .go    (prog_go),
        .viol  (viol_pulse)
    );
endmodule

// File: rtl/fwp_guard_sva.sv
module fwp_guard_sva #(
    parameter int REQ_PAGE_W = 8,
    parameter int LAST_PAGE  = 63
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic                  req_valid,
    input logic [REQ_PAGE_W-1:0] req_page,
    input logic                  prog_go,
    input logic                  viol_pulse,
    input logic                  cfg_err
);
    localparam logic [REQ_PAGE_W:0] LAST_X = (REQ_PAGE_W+1)'(LAST_PAGE);

    assert_single_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, viol_pulse}));

    assert_request_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (prog_go || viol_pulse));

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!prog_go && !viol_pulse));

    assert_beyond_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_page} > LAST_X)) |=> viol_pulse);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_we));
endmodule

bind fwp_guard fwp_guard_sva #(
    .REQ_PAGE_W (REQ_PAGE_W),
    .LAST_PAGE  (LAST_PAGE)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .req_valid  (req_valid),
    .req_page   (req_page),
    .prog_go    (prog_go),
    .viol_pulse (viol_pulse),
    .cfg_err    (cfg_err)
);

// File: tb/fwp_guard_tb_top.sv
module fwp_guard_tb_top;
    localparam int FKB   = 16;
    localparam int PW    = 5;
    localparam int LASTP = FKB - 1;   // 1 KB pages

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [9:0]    cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_page = '0;
    logic          prog_go, viol_pulse, cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fwp_guard #(.FLASH_KB(FKB), .PAGE_BYTES(1024), .REQ_PAGE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_page(req_page),
        .prog_go(prog_go), .viol_pulse(viol_pulse), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [9:0] w);
        cfg_wdata = w;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Issue a request, return {go, viol} seen one cycle later.
    task automatic send(input int p, output logic g, output logic v);
        req_page  = PW'(p);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g = prog_go;
        v = viol_pulse;
    endtask

    function automatic bit allowed(int b, bit dir, bit off, bit opn, int p);
        bit hit;
        if (p > LASTP) return 1'b0;
        hit = !off && (dir ? (p >= b) : (p <= b));
        if (p == LASTP && !opn) return 1'b0;
        return !hit;
    endfunction

    function automatic string tag_of(int b, bit dir, bit off, bit opn, int p);
        if (p > LASTP) return "R2";
        if (off) return "R5";
        if (p == LASTP) return opn ? "R7" : "R6";
        if (dir && b > LASTP) return "R10";
        return dir ? "R3" : "R4";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int bnds[8] = '{0, 1, 7, 14, 15, 16, 63, 127};
        logic g, v;
        bit   e;

        // R1: reset state
        do_reset();
        check("R1 cfg_err after reset", int'(cfg_err), 0);
        check("R1 go idle", int'(prog_go), 0);
        for (int p = 0; p < 20; p++) begin
            send(p, g, v);
            e = (p <= LASTP);
            check(p > LASTP ? "R2 reset default" : "R1 reset default", int'(g), int'(e));
            check("R9 exclusive", int'(g & v), 0);
            check(p > LASTP ? "R2 violation" : "R1 violation", int'(v), int'(!e));
        end
        send(31, g, v);
        check("R2 page 31", int'(v), 1);
        @(negedge clk);
        check("R9 pulse length go", int'(prog_go), 0);
        check("R9 pulse length viol", int'(viol_pulse), 0);

        // Sweep configurations (R3..R7, R10)
        foreach (bnds[i]) begin
            for (int c = 0; c < 8; c++) begin
                bit dir = c[0];
                bit off = c[1];
                bit opn = c[2];
                do_reset();
                load_cfg({opn, off, dir, 7'(bnds[i])});
                for (int p = 0; p < 20; p++) begin
                    send(p, g, v);
                    e = allowed(bnds[i], dir, off, opn, p);
                    check(tag_of(bnds[i], dir, off, opn, p), int'(g), int'(e));
                    check("R9 one response", int'(g ^ v), 1);
                end
                check("R8 no error after first load", int'(cfg_err), 0);
            end
        end

        // R8: second load ignored, error sticky
        do_reset();
        load_cfg({1'b0, 1'b0, 1'b0, 7'd3});
        check("R8 err after first", int'(cfg_err), 0);
        load_cfg(10'h3FF);
        check("R8 err after second", int'(cfg_err), 1);
        send(2, g, v);
        check("R8 first config kept low span", int'(v), 1);
        send(LASTP, g, v);
        check("R8 first config kept cfg page", int'(v), 1);
        send(8, g, v);
        check("R8 outside span", int'(g), 1);
        repeat (3) @(negedge clk);
        check("R8 err sticky", int'(cfg_err), 1);
        do_reset();
        check("R8 err cleared by reset", int'(cfg_err), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule